// File: doc/BRIEF.md
# Trap Entry Control Unit

This block carries out the control and status register changes that a processor core makes when it accepts a trap. It takes a trap request along with the current program counter and privilege level. The request says whether the trap is an interrupt or an exception, and it carries a cause code and a faulting address.

From these inputs the block decides which level handles the trap, supervisor or machine. It then saves the interrupt-enable stack, the cause, the trapping PC and the trap value in that level's registers. Finally it presents the handler address and the new privilege level, together with a one-cycle taken pulse.

A small write port loads the two handler base registers, the two delegation masks and the status word. Trap return and general register access are handled elsewhere. Privilege is encoded U=0, S=1, M=3.

Top module: `trap_entry`

## Requirements
- R1: A trap goes to supervisor level only when the current privilege is U or S and the delegation mask bit indexed by the effective cause is 1. The interrupt mask is used for interrupts and the exception mask for exceptions. Every other trap goes to machine level, including any trap raised from M.
- R2: On a supervisor entry, status bit 2 (supervisor previous enable) takes the old bit 0 (supervisor enable). Bit 4 (supervisor previous privilege) takes 1 if the trap came from S and 0 if it came from U. Bit 0 is cleared. The machine bits keep their values.
- R3: On a machine entry, status bit 3 (machine previous enable) takes the old bit 1 (machine enable). Bits 6:5 (machine previous privilege) take the current privilege. Bit 1 is cleared. The supervisor bits keep their values.
- R4: The handling level's cause register holds the effective cause code in its low bits and has its most significant bit set only for interrupts.
- R5: The handling level's exception PC register receives the trapping PC.
- R6: The new PC is the handling level's base register with bits 1:0 forced to zero. When the trap is an interrupt and that register's bits 1:0 equal 1, four times the cause is added. Exceptions always use the plain base.
- R7: The handling level's trap value register receives the faulting address for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It receives zero for every other exception and for every interrupt.
- R8: An exception with cause 8 becomes cause 8 when raised from U, 9 from S and 11 from M. Delegation uses the remapped code.
- R9: A trap whose cause is 32 or more is never delegated, whatever the low bits select in the mask.
- R10: Every update lands at the clock edge that accepts the request. The taken output is high for exactly the following cycle. Without a request or a configuration write, all outputs hold their values.
- R11: After entry the output privilege is 1 for a supervisor handler and 3 for a machine handler.
- R12: After reset the privilege output is 3 and the taken output is 0. The PC, status and all trap registers read zero.
- R13: The write port selects its target with the select input: 0 machine base, 1 supervisor base, 2 exception delegation mask, 3 interrupt delegation mask, 4 status word. The status word uses bits 6:0 in the layout of R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_req | input | 1 | Trap accepted this cycle |
| trap_irq | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause | input | CAUSE_W | Raw cause code |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege level |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration target select |
| cfg_wdata | input | XLEN | Configuration write data |
| trap_taken_o | output | 1 | One-cycle pulse after entry |
| new_pc_o | output | XLEN | Handler address |
| new_priv_o | output | 2 | Privilege after entry |
| status_o | output | 7 | Interrupt-enable stack |
| mcause_o | output | XLEN | Machine cause register |
| mepc_o | output | XLEN | Machine exception PC |
| mtval_o | output | XLEN | Machine trap value |
| scause_o | output | XLEN | Supervisor cause register |
| sepc_o | output | XLEN | Supervisor exception PC |
| stval_o | output | XLEN | Supervisor trap value |

## Verification
Traps are fired from U, S and M, as exceptions and as interrupts, with causes whose delegation bits are set and clear. This separates the mask-based routing from the privilege override, and the interrupt mask from the exception mask. Cause 8 is raised from all three levels to show that the remap feeds delegation. Address-bearing causes are contrasted with breakpoint and interrupt causes to expose the trap value filter. An interrupt of cause 33 with low bits that hit a set mask bit, taken through the vectored machine base, shows both the range rule and the vector offset arithmetic.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_R = 2'b10,
        PRIV_M = 2'b11
    } priv_e;

    // Interrupt-enable stack; packed MSB first -> bits 6:0
    typedef struct packed {
        logic [1:0] mpp;   // 6:5
        logic       spp;   // 4
        logic       mpie;  // 3
        logic       spie;  // 2
        logic       mie;   // 1
        logic       sie;   // 0
    } stat_t;

    typedef enum logic [2:0] {
        CFG_MBASE  = 3'd0,
        CFG_SBASE  = 3'd1,
        CFG_EXDLG  = 3'd2,
        CFG_IRQDLG = 3'd3,
        CFG_STATUS = 3'd4
    } cfg_sel_e;

    localparam int unsigned ENV_CALL_U = 8;
    localparam int unsigned ENV_CALL_S = 9;
    localparam int unsigned ENV_CALL_M = 11;

endpackage

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int unsigned CAUSE_W = 6,
    parameter int unsigned DLG_W   = 32
) (
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic [1:0]         cur_priv,
    input  logic [DLG_W-1:0]   exc_dlg,
    input  logic [DLG_W-1:0]   irq_dlg,
    output logic [CAUSE_W-1:0] cause_eff,
    output logic               to_super,
    output logic               keeps_addr
);
    localparam int unsigned IDX_W = $clog2(DLG_W);

    logic [DLG_W-1:0] dlg_vec;
    logic             in_range;

    // environment-call remap, then delegation on the remapped code
    always_comb begin
        cause_eff = cause_in;
        if (!is_irq && int'(cause_in) == ENV_CALL_U) begin
            case (priv_e'(cur_priv))
                PRIV_S:  cause_eff = CAUSE_W'(ENV_CALL_S);
                PRIV_M:  cause_eff = CAUSE_W'(ENV_CALL_M);
                default: cause_eff = CAUSE_W'(ENV_CALL_U);
            endcase
        end
    end

    always_comb begin
        dlg_vec  = is_irq ? irq_dlg : exc_dlg;
        in_range = int'(cause_eff) < int'(DLG_W);
        to_super = (priv_e'(cur_priv) != PRIV_M) && in_range
                   && dlg_vec[cause_eff[IDX_W-1:0]];
    end

    // address-bearing exceptions: misaligned, access and page faults
    always_comb begin
        keeps_addr = 1'b0;
        if (!is_irq) begin
            case (int'(cause_eff))
                0, 1, 4, 5, 6, 7, 12, 13, 15: keeps_addr = 1'b1;
                default:                      keeps_addr = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned CAUSE_W    = 6,
    parameter bit          VECTOR_EN  = 1'b1
) (
    input  logic [XLEN-1:0]    tvec,
    input  logic               is_irq,
    input  logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    target
);
    logic [XLEN-1:0] base;

    assign base = {tvec[XLEN-1:2], 2'b00};

    generate
        if (VECTOR_EN) begin : g_vectored
            logic use_vec;
            assign use_vec = is_irq && (tvec[1:0] == 2'b01);
            assign target  = base + (use_vec ? (XLEN'(cause) << 2) : '0);
        end else begin : g_direct
            assign target = base;
        end
    endgenerate

endmodule

// File: rtl/trap_entry.sv
module trap_entry
    import trap_pkg::*;
#(
    parameter int unsigned XLEN    = 32,
    parameter int unsigned CAUSE_W = 6,
    parameter int unsigned DLG_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_req,
    input  logic               trap_irq,
    input  logic [CAUSE_W-1:0] trap_cause,
    input  logic [XLEN-1:0]    trap_addr,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [1:0]         cur_priv,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [XLEN-1:0]    cfg_wdata,
    output logic               trap_taken_o,
    output logic [XLEN-1:0]    new_pc_o,
    output logic [1:0]         new_priv_o,
    output logic [6:0]         status_o,
    output logic [XLEN-1:0]    mcause_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    mtval_o,
    output logic [XLEN-1:0]    scause_o,
    output logic [XLEN-1:0]    sepc_o,
    output logic [XLEN-1:0]    stval_o
);
    localparam int unsigned PAD_W = XLEN - 1 - CAUSE_W;

    typedef struct packed {
        logic             taken;
        logic [XLEN-1:0]  pc;
        priv_e            priv;
        stat_t            st;
        logic [XLEN-1:0]  mbase;
        logic [XLEN-1:0]  sbase;
        logic [DLG_W-1:0] exdlg;
        logic [DLG_W-1:0] irqdlg;
        logic [XLEN-1:0]  mcause;
        logic [XLEN-1:0]  mepc;
        logic [XLEN-1:0]  mtval;
        logic [XLEN-1:0]  scause;
        logic [XLEN-1:0]  sepc;
        logic [XLEN-1:0]  stval;
    } state_t;

    state_t st_d, st_q;

    logic [CAUSE_W-1:0] cause_eff;
    logic               to_super;
    logic               keeps_addr;
    logic [XLEN-1:0]    tvec_sel;
    logic [XLEN-1:0]    handler_pc;
    logic [XLEN-1:0]    cause_word;
    logic [XLEN-1:0]    tval_word;

    trap_route #(.CAUSE_W(CAUSE_W), .DLG_W(DLG_W)) i_route (
        .is_irq     (trap_irq),
        .cause_in   (trap_cause),
        .cur_priv   (cur_priv),
        .exc_dlg    (st_q.exdlg),
        .irq_dlg    (st_q.irqdlg),
        .cause_eff  (cause_eff),
        .to_super   (to_super),
        .keeps_addr (keeps_addr)
    );

    assign tvec_sel = to_super ? st_q.sbase : st_q.mbase;

    trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VECTOR_EN(1'b1)) i_vector (
        .tvec   (tvec_sel),
        .is_irq (trap_irq),
        .cause  (cause_eff),
        .target (handler_pc)
    );

    assign cause_word = {trap_irq, {PAD_W{1'b0}}, cause_eff};
    assign tval_word  = keeps_addr ? trap_addr : '0;

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;

        if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_MBASE:  st_d.mbase  = cfg_wdata;
                CFG_SBASE:  st_d.sbase  = cfg_wdata;
                CFG_EXDLG:  st_d.exdlg  = DLG_W'(cfg_wdata);
                CFG_IRQDLG: st_d.irqdlg = DLG_W'(cfg_wdata);
                CFG_STATUS: st_d.st     = stat_t'(cfg_wdata[6:0]);
                default:    ;
            endcase
        end

        // trap acceptance wins over a status write in the same cycle
        if (trap_req) begin
            st_d.taken = 1'b1;
            st_d.pc    = handler_pc;
            if (to_super) begin
                st_d.priv    = PRIV_S;
                st_d.scause  = cause_word;
                st_d.sepc    = cur_pc;
                st_d.stval   = tval_word;
                st_d.st.spie = st_q.st.sie;
                st_d.st.spp  = cur_priv[0];
                st_d.st.sie  = 1'b0;
            end else begin
                st_d.priv    = PRIV_M;
                st_d.mcause  = cause_word;
                st_d.mepc    = cur_pc;
                st_d.mtval   = tval_word;
                st_d.st.mpie = st_q.st.mie;
                st_d.st.mpp  = cur_priv;
                st_d.st.mie  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_taken_o = st_q.taken;
    assign new_pc_o     = st_q.pc;
    assign new_priv_o   = st_q.priv;
    assign status_o     = st_q.st;
    assign mcause_o     = st_q.mcause;
    assign mepc_o       = st_q.mepc;
    assign mtval_o      = st_q.mtval;
    assign scause_o     = st_q.scause;
    assign sepc_o       = st_q.sepc;
    assign stval_o      = st_q.stval;

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken_o |-> new_pc_o[1:0] == 2'b00); // R6
    AST_HANDLER_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken_o |-> (new_priv_o == 2'b01 || new_priv_o == 2'b11)); // R11
    AST_M_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken_o && new_priv_o == 2'b11) |-> !status_o[1]); // R3
    AST_S_IE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken_o && new_priv_o == 2'b01) |-> !status_o[0]); // R2
    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (mepc_o == $past(cur_pc) || sepc_o == $past(cur_pc))); // R5
    AST_FROM_M_STAYS_M: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && cur_priv == 2'b11) |=> new_priv_o == 2'b11); // R1
    AST_HIGH_CAUSE_M: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && int'(trap_cause) >= int'(DLG_W)) |=> new_priv_o == 2'b11); // R9
    AST_IRQ_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_irq) |=> (mcause_o[XLEN-1] || scause_o[XLEN-1])); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !cfg_we) |=> ($stable(new_pc_o) && $stable(status_o) && !trap_taken_o)); // R10

endmodule

// File: tb/test_trap_entry.sv
module test_trap_entry;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic        trap_irq = 1'b0;
    logic [5:0]  trap_cause = '0;
    logic [31:0] trap_addr = '0;
    logic [31:0] cur_pc = '0;
    logic [1:0]  cur_priv = 2'b00;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        trap_taken_o;
    logic [31:0] new_pc_o;
    logic [1:0]  new_priv_o;
    logic [6:0]  status_o;
    logic [31:0] mcause_o, mepc_o, mtval_o, scause_o, sepc_o, stval_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    trap_entry i_trap_entry (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
        .trap_cause(trap_cause), .trap_addr(trap_addr), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .trap_taken_o(trap_taken_o), .new_pc_o(new_pc_o), .new_priv_o(new_priv_o),
        .status_o(status_o), .mcause_o(mcause_o), .mepc_o(mepc_o), .mtval_o(mtval_o),
        .scause_o(scause_o), .sepc_o(sepc_o), .stval_o(stval_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // enable stack starts as sie=1, mie=1 (status 0x03) before every trap
    task automatic fire(input logic irq, input logic [5:0] cause, input logic [31:0] addr,
                        input logic [31:0] pc, input logic [1:0] priv);
        cfg_write(3'd4, 32'h03);
        trap_req = 1'b1; trap_irq = irq; trap_cause = cause;
        trap_addr = addr; cur_pc = pc; cur_priv = priv;
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    task automatic t_reset;
        chk("R12 priv", {30'd0, new_priv_o}, 32'd3);
        chk("R12 taken", {31'd0, trap_taken_o}, 32'd0);
        chk("R12 pc", new_pc_o, 32'd0);
        chk("R12 status", {25'd0, status_o}, 32'd0);
        chk("R12 mcause", mcause_o, 32'd0);
    endtask

    task automatic t_illegal_from_u;
        fire(1'b0, 6'd2, 32'h1234, 32'h100, 2'b00);
        chk("R1 priv", {30'd0, new_priv_o}, 32'd3);
        chk("R4 mcause", mcause_o, 32'd2);
        chk("R5 mepc", mepc_o, 32'h100);
        chk("R7 mtval zero", mtval_o, 32'd0);
        chk("R6 exc plain base", new_pc_o, 32'h1000_0000);
        chk("R3 stack", {25'd0, status_o}, 32'h09);
        chk("R10 taken", {31'd0, trap_taken_o}, 32'd1);
    endtask

    task automatic t_ecall_u;
        fire(1'b0, 6'd8, 32'h0, 32'h200, 2'b00);
        chk("R11 priv S", {30'd0, new_priv_o}, 32'd1);
        chk("R8 scause", scause_o, 32'd8);
        chk("R5 sepc", sepc_o, 32'h200);
        chk("R6 sbase", new_pc_o, 32'h2000_0000);
        chk("R2 stack", {25'd0, status_o}, 32'h06);
        chk("R10 taken", {31'd0, trap_taken_o}, 32'd1);
        @(negedge clk);
        chk("R10 pulse ends", {31'd0, trap_taken_o}, 32'd0);
        chk("R10 pc held", new_pc_o, 32'h2000_0000);
        chk("R10 status held", {25'd0, status_o}, 32'h06);
    endtask

    task automatic t_ecall_s;
        fire(1'b0, 6'd8, 32'h0, 32'h300, 2'b01);
        chk("R8 from S", mcause_o, 32'd9);
        chk("R1 not delegated", {30'd0, new_priv_o}, 32'd3);
        chk("R3 mpp S", {25'd0, status_o}, 32'h29);
    endtask

    task automatic t_ecall_m;
        fire(1'b0, 6'd8, 32'h0, 32'h400, 2'b11);
        chk("R8 from M", mcause_o, 32'd11);
        chk("R1 M never delegates", {30'd0, new_priv_o}, 32'd3);
        chk("R3 mpp M", {25'd0, status_o}, 32'h69);
    endtask

    task automatic t_page_fault_s;
        fire(1'b0, 6'd13, 32'hCAFE_F00C, 32'h500, 2'b01);
        chk("R1 delegated", {30'd0, new_priv_o}, 32'd1);
        chk("R7 stval", stval_o, 32'hCAFE_F00C);
        chk("R4 scause", scause_o, 32'd13);
        chk("R2 spp S", {25'd0, status_o}, 32'h16);
    endtask

    task automatic t_access_fault_u;
        fire(1'b0, 6'd5, 32'h0000_ABCD, 32'h600, 2'b00);
        chk("R7 mtval", mtval_o, 32'h0000_ABCD);
        chk("R4 mcause", mcause_o, 32'd5);
    endtask

    task automatic t_breakpoint;
        fire(1'b0, 6'd3, 32'h55, 32'h700, 2'b00);
        chk("R7 breakpoint zero", mtval_o, 32'd0);
    endtask

    task automatic t_irq_m;
        fire(1'b1, 6'd7, 32'h77, 32'h800, 2'b00);
        chk("R4 irq msb", mcause_o, 32'h8000_0007);
        chk("R6 vectored", new_pc_o, 32'h1000_001C);
        chk("R7 irq zero", mtval_o, 32'd0);
    endtask

    task automatic t_irq_s;
        fire(1'b1, 6'd5, 32'h0, 32'h900, 2'b01);
        chk("R1 irq mask", {30'd0, new_priv_o}, 32'd1);
        chk("R4 scause irq", scause_o, 32'h8000_0005);
        chk("R6 direct", new_pc_o, 32'h2000_0000);
    endtask

    task automatic t_irq_high;
        fire(1'b1, 6'd1, 32'h0, 32'hA00, 2'b01);
        chk("R1 irq 1 delegated", {30'd0, new_priv_o}, 32'd1);
        fire(1'b1, 6'd33, 32'h0, 32'hB00, 2'b00);
        chk("R9 high cause M", {30'd0, new_priv_o}, 32'd3);
        chk("R9 mcause", mcause_o, 32'h8000_0021);
        chk("R6 offset 33", new_pc_o, 32'h1000_0084);
    endtask

    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        // R13 select encoding
        cfg_write(3'd0, 32'h1000_0001);
        cfg_write(3'd1, 32'h2000_0000);
        cfg_write(3'd2, 32'h0000_2900);
        cfg_write(3'd3, 32'h0000_0022);
        cfg_write(3'd4, 32'h03);
        chk("R13 status write", {25'd0, status_o}, 32'h03);
        t_illegal_from_u();
        t_ecall_u();
        t_ecall_s();
        t_ecall_m();
        t_page_fault_s();
        t_access_fault_u();
        t_breakpoint();
        t_irq_m();
        t_irq_s();
        t_irq_high();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule